// File: doc/BRIEF.md
# Segmented Paging Translation Unit

This block turns a 32-bit virtual address into a 30-bit physical address by a two-step walk. The top three bits pick one of eight segment slots. Each slot holds the physical byte address where that segment's page table begins, and the highest page index the table may be asked for. The unit compares the 17-bit virtual page number with that limit. If the page number is within the limit, the unit reads one page table entry from external memory and joins the 18-bit physical page number it returns with the untouched 12-bit page offset.

Software loads the segment slots through a plain write port. Translations enter and leave through valid/ready streams. The request stream accepts a new address only while the unit is idle. The result stream holds its data until the consumer takes it, so back-pressure on the result side stalls the unit. The memory read port also uses valid/ready. The memory's answer is a valid pulse that the unit accepts only while it is waiting for one. A page number beyond the limit comes back as a fault, and no memory traffic is made for it.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address is split as segment = bits 31:29, virtual page number = bits 28:12 and page offset = bits 11:0.
- R2: The eight segment slots are written through seg_wr_en/seg_wr_idx/seg_wr_base/seg_wr_bound. A request accepted in the same cycle as a write to its own slot uses the slot's old contents. Requests accepted later use the new contents. A write to one slot leaves the other slots unchanged.
- R3: When the page number is greater than the slot's bound, the response has rsp_fault=1 and rsp_paddr=0, and no memory read is issued. A page number equal to the bound does not fault.
- R4: The entry read address is (slot base + page number × 4) modulo 2^30. mem_rd_addr stays stable while mem_rd_valid is high and mem_rd_ready is low.
- R5: For a non-faulting request, rsp_paddr = {returned 18-bit page number, offset} and rsp_fault=0.
- R6: Only one translation is in flight at a time. req_ready is low from the acceptance of a request until its response is taken (rsp_valid and rsp_ready both high), and it is high again in the cycle after that.
- R7: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_paddr and rsp_fault stay stable.
- R8: After reset, req_ready=1, rsp_valid=0 and mem_rd_valid=0, and every slot holds base 0 and bound 0.
- R9: Each non-faulting translation issues exactly one memory read. mem_resp_ready is high only while the unit waits for that read's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment slot write strobe |
| seg_wr_idx | input | 3 | Slot being written |
| seg_wr_base | input | 30 | Page table start address (bytes) |
| seg_wr_bound | input | 17 | Highest legal page index for the slot |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 30 | Byte address of the page table entry |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_ready | output | 1 | Unit waiting for read data |
| mem_resp_data | input | 18 | Physical page number from the entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page number exceeded the bound |

## Verification
The hardest case to reach from the ports is a slot write that lands in the very cycle a request for that slot is accepted. The outcome depends on whether the table is read before or after the write. The bench raises the write strobe and req_valid on the same falling edge while the unit is idle, so both happen at one rising edge. It then checks that the read address still comes from the old base, and that the next request uses the new one. Entry addresses that wrap past the top of the 30-bit space, and page numbers exactly at the bound and one above it, are reached by loading chosen base and bound values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    XL_IDLE  = 2'd0,
    XL_ISSUE = 2'd1,
    XL_WAIT  = 2'd2,
    XL_RESP  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/xl_seg_table.sv
module xl_seg_table #(
  parameter int SEG_W = 3,
  parameter int VPN_W = 17,
  parameter int PA_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [VPN_W-1:0] wr_bound,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [VPN_W-1:0] rd_bound
);
  localparam int NSEG = 1 << SEG_W;

  logic [NSEG*PA_W-1:0]  base_flat;
  logic [NSEG*VPN_W-1:0] bound_flat;

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    logic [PA_W-1:0]  base_q;
    logic [VPN_W-1:0] bound_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        bound_q <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q  <= wr_base;
        bound_q <= wr_bound;
      end
    end
    assign base_flat[g*PA_W +: PA_W]    = base_q;
    assign bound_flat[g*VPN_W +: VPN_W] = bound_q;
  end

  // Read sees register contents, so a same-cycle write is not visible yet.
  assign rd_base  = base_flat[rd_idx*PA_W +: PA_W];
  assign rd_bound = bound_flat[rd_idx*VPN_W +: VPN_W];
endmodule

// File: rtl/xl_bound_calc.sv
module xl_bound_calc #(
  parameter int VPN_W     = 17,
  parameter int PA_W      = 30,
  parameter int PTE_BYTES = 4
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] bound,
  output logic             over,
  output logic [PA_W-1:0]  pte_addr
);
  localparam int PTE_SH = $clog2(PTE_BYTES);

  assign over     = vpn > bound;
  assign pte_addr = base + (PA_W'(vpn) << PTE_SH);
endmodule

// File: rtl/xl_walk_ctrl.sv
module xl_walk_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int PA_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] in_off,
  input  logic             in_over,
  input  logic [PA_W-1:0]  in_pte_addr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_resp_valid,
  output logic             mem_resp_ready,
  input  logic [PPN_W-1:0] mem_resp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  xl_state_e        st_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= XL_IDLE;
      off_q   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        XL_IDLE: if (req_valid) begin
          off_q <= in_off;
          if (in_over) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            st_q    <= XL_RESP;
          end else begin
            addr_q <= in_pte_addr;
            st_q   <= XL_ISSUE;
          end
        end
        XL_ISSUE: if (mem_rd_ready) st_q <= XL_WAIT;
        XL_WAIT: if (mem_resp_valid) begin
          paddr_q <= {mem_resp_data, off_q};
          fault_q <= 1'b0;
          st_q    <= XL_RESP;
        end
        XL_RESP: if (rsp_ready) st_q <= XL_IDLE;
        default: st_q <= XL_IDLE;
      endcase
    end
  end

  assign req_ready      = (st_q == XL_IDLE);
  assign mem_rd_valid   = (st_q == XL_ISSUE);
  assign mem_resp_ready = (st_q == XL_WAIT);
  assign rsp_valid      = (st_q == XL_RESP);
  assign mem_rd_addr    = addr_q;
  assign rsp_paddr      = paddr_q;
  assign rsp_fault      = fault_q;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int SEG_W     = 3,
  parameter int VPN_W     = 17,
  parameter int OFF_W     = 12,
  parameter int PPN_W     = 18,
  parameter int PTE_BYTES = 4,
  parameter int VA_W      = SEG_W + VPN_W + OFF_W,
  parameter int PA_W      = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [SEG_W-1:0] seg_wr_idx,
  input  logic [PA_W-1:0]  seg_wr_base,
  input  logic [VPN_W-1:0] seg_wr_bound,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_resp_valid,
  output logic             mem_resp_ready,
  input  logic [PPN_W-1:0] mem_resp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  logic [SEG_W-1:0] va_seg;
  logic [VPN_W-1:0] va_vpn;
  logic [OFF_W-1:0] va_off;
  logic [PA_W-1:0]  sel_base;
  logic [VPN_W-1:0] sel_bound;
  logic             over;
  logic [PA_W-1:0]  pte_addr;

  assign va_seg = req_vaddr[VA_W-1 -: SEG_W];
  assign va_vpn = req_vaddr[OFF_W +: VPN_W];
  assign va_off = req_vaddr[OFF_W-1:0];

  xl_seg_table #(.SEG_W(SEG_W), .VPN_W(VPN_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_idx(seg_wr_idx), .wr_base(seg_wr_base), .wr_bound(seg_wr_bound),
    .rd_idx(va_seg), .rd_base(sel_base), .rd_bound(sel_bound)
  );

  xl_bound_calc #(.VPN_W(VPN_W), .PA_W(PA_W), .PTE_BYTES(PTE_BYTES)) u_calc (
    .vpn(va_vpn), .base(sel_base), .bound(sel_bound),
    .over(over), .pte_addr(pte_addr)
  );

  xl_walk_ctrl #(.OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .in_off(va_off), .in_over(over), .in_pte_addr(pte_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_ready(mem_resp_ready), .mem_resp_data(mem_resp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_resp_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault
);
  logic rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_seen <= 1'b0;
    else if (req_valid && req_ready) rd_seen <= 1'b0;
    else if (mem_rd_valid && mem_rd_ready) rd_seen <= 1'b1;
  end

  // R3
  fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rd_seen && rsp_paddr == '0));

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !rd_seen);

  // R9
  ok_had_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rd_seen);

  // R6
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_valid, mem_resp_ready, rsp_valid}));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind seg_page_xlate seg_page_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_resp_ready(mem_resp_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/test_seg_page_xlate.sv
module test_seg_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [2:0]  seg_wr_idx = '0;
  logic [29:0] seg_wr_base = '0;
  logic [16:0] seg_wr_bound = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [29:0] mem_rd_addr;
  logic        mem_resp_valid = 1'b0;
  logic        mem_resp_ready;
  logic [17:0] mem_resp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [29:0] rsp_paddr;
  logic        rsp_fault;

  int          n_checks = 0;
  int          n_fails = 0;
  int          rd_count = 0;
  int          mem_stall = 0;
  int          resp_gap = 0;
  logic [29:0] last_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_page_xlate i_seg_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_base(seg_wr_base), .seg_wr_bound(seg_wr_bound),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_ready(mem_resp_ready), .mem_resp_data(mem_resp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  function automatic logic [17:0] pte_of(input logic [29:0] a);
    return a[19:2] ^ 18'h2A5A5 ^ {a[29:20], 8'h00};
  endfunction

  function automatic logic [31:0] mkva(input int s, input int v, input int o);
    return {3'(s), 17'(v), 12'(o)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model: accepts reads after mem_stall cycles, answers after resp_gap cycles.
  initial begin
    logic [29:0] first;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        first = mem_rd_addr;
        repeat (mem_stall) @(negedge clk);
        chk("R4 read address held during stall", 32'(mem_rd_addr), 32'(first));
        last_addr = mem_rd_addr;
        mem_rd_ready = 1'b1;
        @(posedge clk);
        #1 mem_rd_ready = 1'b0;
        rd_count++;
        repeat (resp_gap) @(negedge clk);
        mem_resp_valid = 1'b1;
        mem_resp_data = pte_of(last_addr);
        @(posedge clk);
        #1 mem_resp_valid = 1'b0;
      end
    end
  end

  task automatic seg_write(input int idx, input logic [29:0] b, input logic [16:0] bd);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_idx = 3'(idx); seg_wr_base = b; seg_wr_bound = bd;
    @(posedge clk);
    #1 seg_wr_en = 1'b0;
  endtask

  task automatic send(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk("R6 busy after accept", 32'(req_ready), 32'd0);
  endtask

  task automatic get_rsp(input int hold, output logic [29:0] pa, output logic flt);
    @(negedge clk);
    while (!rsp_valid) begin
      chk("R6 no accept while in flight", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    pa = rsp_paddr; flt = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 response held under back-pressure", {rsp_valid, rsp_fault, rsp_paddr}, {1'b1, flt, pa});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    chk("R6 ready after handoff", 32'(req_ready), 32'd1);
  endtask

  task automatic xlate(input logic [31:0] va, input int hold,
                       output logic [29:0] pa, output logic flt, output int nrd);
    int r0;
    r0 = rd_count;
    send(va);
    get_rsp(hold, pa, flt);
    nrd = rd_count - r0;
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] va, input logic [29:0] base, input int hold);
    logic [29:0] pa, ea; logic flt; int nrd;
    xlate(va, hold, pa, flt, nrd);
    ea = base + {11'd0, va[28:12], 2'b00};
    chk({tag, " R9 one read"}, 32'(nrd), 32'd1);
    chk({tag, " R4 entry address"}, 32'(last_addr), 32'(ea));
    chk({tag, " R5 fault clear"}, 32'(flt), 32'd0);
    chk({tag, " R1 R5 physical address"}, 32'(pa), 32'({pte_of(ea), va[11:0]}));
  endtask

  task automatic expect_fault(input string tag, input logic [31:0] va);
    logic [29:0] pa; logic flt; int nrd;
    xlate(va, 1, pa, flt, nrd);
    chk({tag, " R3 fault flag"}, 32'(flt), 32'd1);
    chk({tag, " R3 zero address"}, 32'(pa), 32'd0);
    chk({tag, " R3 no memory read"}, 32'(nrd), 32'd0);
  endtask

  task automatic t_reset();
    chk("R8 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R8 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R8 mem_rd_valid after reset", 32'(mem_rd_valid), 32'd0);
    expect_ok("R8 cleared slot page 0", mkva(5, 0, 12'h123), 30'd0, 0);
    expect_fault("R8 cleared slot page 1", mkva(5, 1, 0));
  endtask

  task automatic t_basic();
    seg_write(2, 30'h0010_0000, 17'd100);
    expect_ok("R1 basic", mkva(2, 37, 12'hABC), 30'h0010_0000, 0);
    expect_ok("R1 offset max", mkva(2, 0, 12'hFFF), 30'h0010_0000, 2);
  endtask

  task automatic t_bound();
    expect_ok("R3 page equal to bound", mkva(2, 100, 12'h010), 30'h0010_0000, 0);
    expect_fault("R3 page bound+1", mkva(2, 101, 12'h010));
    expect_fault("R3 page max", mkva(2, 17'h1FFFF, 0));
  endtask

  task automatic t_backpressure();
    mem_stall = 3; resp_gap = 2;
    expect_ok("R7 stalls", mkva(2, 9, 12'h555), 30'h0010_0000, 4);
    mem_stall = 0; resp_gap = 0;
  endtask

  task automatic t_same_cycle_write();
    logic [29:0] pa; logic flt;
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_idx = 3'd2; seg_wr_base = 30'h0020_0000; seg_wr_bound = 17'd100;
    req_valid = 1'b1; req_vaddr = mkva(2, 5, 12'h0AA);
    @(posedge clk);
    #1 begin seg_wr_en = 1'b0; req_valid = 1'b0; end
    get_rsp(0, pa, flt);
    chk("R2 same-cycle write not seen", 32'(last_addr), 32'(30'h0010_0000 + 30'd20));
    expect_ok("R2 later request sees write", mkva(2, 5, 12'h0AA), 30'h0020_0000, 0);
  endtask

  task automatic t_wrap();
    seg_write(6, 30'h3FFF_FFF0, 17'h1FFFF);
    expect_ok("R4 address wrap", mkva(6, 8, 12'h321), 30'h3FFF_FFF0, 0);
    expect_ok("R4 top page", mkva(6, 17'h1FFFF, 12'h001), 30'h3FFF_FFF0, 0);
  endtask

  task automatic t_all_slots();
    for (int s = 0; s < 8; s++) seg_write(s, 30'(s * 30'h0100_0000 + 30'h40 * s), 17'(10 + s));
    for (int s = 0; s < 8; s++)
      expect_ok("R2 per-slot", mkva(s, 3 + s, 12'h7 * s), 30'(s * 30'h0100_0000 + 30'h40 * s), s % 2);
    expect_fault("R2 slot 7 bound", mkva(7, 18, 0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bound();
    t_backpressure();
    t_same_cycle_write();
    t_wrap();
    t_all_slots();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule